// File: doc/BRIEF.md
# Dual-Bank Hashed Recent-Request Table

This block keeps a short history of cache-line addresses for an offset-learning prefetch engine. The engine uses it to ask one question: was this line requested recently? The history is held in two direct-mapped banks, a left bank and a right bank. Each bank stores short tags, one entry per slot.

Each bank has its own write port. A write takes a byte address, reduces it to a line address, and stores a truncated tag at a slot picked by an XOR-fold hash. The two banks use different fold distances, so two lines that collide in one bank usually land in different slots of the other.

A lookup presents a tag and gets a hit flag one cycle later. It searches every valid entry of both banks, not only the hashed slots. Which addresses get written, and when, is decided by the surrounding engine.

Top module: `rrt_table`

## Requirements
- R1: After reset every entry is invalid. A lookup of any tag, including tag 0, returns no hit until that tag is written.
- R2: The stored tag is the byte address shifted right by log2(LINE_BYTES) and then reduced to its low TAG_W bits. Bits below the line boundary and line-address bits above TAG_W have no effect on the tag.
- R3: Left-bank slot index = (L ^ (L >> log2 ENTRIES)) mod ENTRIES, where L is the line address.
- R4: Right-bank slot index = (L ^ (L >> 2·log2 ENTRIES)) mod ENTRIES.
- R5: A write replaces the tag at its slot of the selected bank. The displaced tag no longer hits unless another entry still holds it.
- R6: A lookup hits when the tag equals any valid entry in either bank, whatever slot the entry sits in.
- R7: `lk_hit` is a register. It reflects the lookup presented on the previous clock edge and is 0 after any edge at which `lk_en` was low.
- R8: A write and a lookup in the same cycle: the lookup sees the contents as they were before the write.
- R9: Both banks can be written in the same cycle, and each write lands independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wl_en | input | 1 | Write strobe for the left bank |
| wl_addr | input | ADDR_W | Byte address written to the left bank |
| wr_en | input | 1 | Write strobe for the right bank |
| wr_addr | input | ADDR_W | Byte address written to the right bank |
| lk_en | input | 1 | Lookup request |
| lk_tag | input | TAG_W | Tag to search for |
| lk_hit | output | 1 | Registered lookup result |

## Verification
The hash functions are the hardest part to see from the ports, because a lookup searches every slot and so ignores where an entry sits. The only sign of a slot index is an eviction. The stimulus therefore picks line pairs that the bench's own hash model says collide in one bank but not the other. It writes both lines in turn and then looks for the first tag: a miss shows a shared slot, and a hit shows separate slots. A further sequence fills every left slot with distinct tags and then probes each tag, to show that the search covers all entries.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

    localparam int unsigned DEF_ADDR_W     = 32;
    localparam int unsigned DEF_LINE_BYTES = 64;
    localparam int unsigned DEF_ENTRIES    = 16;
    localparam int unsigned DEF_TAG_W      = 12;
    localparam int unsigned NUM_BANKS      = 2;

    typedef enum int unsigned {
        BANK_LEFT  = 0,
        BANK_RIGHT = 1
    } bank_e;

    // Fold distance per bank: log2(N) for left, 2*log2(N) for right.
    function automatic int unsigned fold_shift(input int unsigned idx_w, input int unsigned bank);
        return (bank == BANK_RIGHT) ? (idx_w << 1) : idx_w;
    endfunction

endpackage

// File: rtl/rrt_index.sv
module rrt_index #(
    parameter int unsigned LINE_W = 26,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned SHIFT  = 4
) (
    input  logic [LINE_W-1:0] line_i,
    output logic [IDX_W-1:0]  idx_o
);
    logic [LINE_W-1:0] folded;

    always_comb begin
        folded = line_i ^ (line_i >> SHIFT);
        idx_o  = folded[IDX_W-1:0];
    end
endmodule

// File: rtl/rrt_bank.sv
module rrt_bank #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned LINE_LG = 6,
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned TAG_W   = 12,
    parameter int unsigned SHIFT   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              any_match
);
    localparam int unsigned IDX_W  = $clog2(ENTRIES);
    localparam int unsigned LINE_W = ADDR_W - LINE_LG;

    logic [LINE_W-1:0]  wr_line;
    logic [IDX_W-1:0]   wr_idx;
    logic [TAG_W-1:0]   wr_tag;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] match_vec;

    assign wr_line = wr_addr[ADDR_W-1:LINE_LG];
    assign wr_tag  = wr_line[TAG_W-1:0];

    rrt_index #(
        .LINE_W (LINE_W),
        .IDX_W  (IDX_W),
        .SHIFT  (SHIFT)
    ) u_index (
        .line_i (wr_line),
        .idx_o  (wr_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match_vec[e] = vld_q[e] && (tag_q[e] == lk_tag);
    end

    assign any_match = |match_vec;

    // R5
    wr_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld_q[$past(wr_idx)]);

    // R5
    wr_stores_tag_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> tag_q[$past(wr_idx)] == $past(wr_tag));

    // R1
    no_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(vld_q));
endmodule

// File: rtl/rrt_table.sv
module rrt_table
    import rrt_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
    parameter int unsigned ENTRIES    = DEF_ENTRIES,
    parameter int unsigned TAG_W      = DEF_TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wl_en,
    input  logic [ADDR_W-1:0] wl_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              lk_en,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit
);
    localparam int unsigned LINE_LG = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W   = $clog2(ENTRIES);

    logic                 bank_en   [NUM_BANKS];
    logic [ADDR_W-1:0]    bank_addr [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_hit;
    logic                 hit_q;

    assign bank_en[BANK_LEFT]    = wl_en;
    assign bank_addr[BANK_LEFT]  = wl_addr;
    assign bank_en[BANK_RIGHT]   = wr_en;
    assign bank_addr[BANK_RIGHT] = wr_addr;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int unsigned SH = fold_shift(IDX_W, b);
        rrt_bank #(
            .ADDR_W  (ADDR_W),
            .LINE_LG (LINE_LG),
            .ENTRIES (ENTRIES),
            .TAG_W   (TAG_W),
            .SHIFT   (SH)
        ) u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (bank_en[b]),
            .wr_addr   (bank_addr[b]),
            .lk_tag    (lk_tag),
            .any_match (bank_hit[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= lk_en && (|bank_hit);
    end

    assign lk_hit = hit_q;

    // R7
    hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> $past(lk_en));
endmodule

// File: tb/rrt_table_tb.sv
`timescale 1ns/100ps
module rrt_table_tb;
    localparam int AW = 32;
    localparam int TW = 12;

    typedef struct packed {
        logic          wl;
        logic [AW-1:0] wla;
        logic          wr;
        logic [AW-1:0] wra;
        logic          lk;
        logic [TW-1:0] tag;
        logic          exp;
        logic [3:0]    req;
    } vec_t;

    // Lines: byte address = line * 64. Expected values from the hash rules.
    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0,     1'b0, 32'h0,    1'b1, 12'h000, 1'b0, 4'd1}, // R1 empty
        '{1'b1, 32'h40,    1'b0, 32'h0,    1'b1, 12'h001, 1'b0, 4'd8}, // R8 old view
        '{1'b0, 32'h0,     1'b0, 32'h0,    1'b1, 12'h001, 1'b1, 4'd7}, // R7 next cycle
        '{1'b1, 32'h400,   1'b0, 32'h0,    1'b1, 12'h010, 1'b0, 4'd8}, // R8
        '{1'b0, 32'h0,     1'b0, 32'h0,    1'b1, 12'h001, 1'b0, 4'd3}, // R3 evicted
        '{1'b0, 32'h0,     1'b0, 32'h0,    1'b1, 12'h010, 1'b1, 4'd3},
        '{1'b1, 32'h4000,  1'b0, 32'h0,    1'b1, 12'h010, 1'b1, 4'd3}, // R3 slot 0
        '{1'b0, 32'h0,     1'b0, 32'h0,    1'b1, 12'h100, 1'b1, 4'd3},
        '{1'b0, 32'h0,     1'b1, 32'h40,   1'b1, 12'h000, 1'b0, 4'd6},
        '{1'b0, 32'h0,     1'b0, 32'h0,    1'b1, 12'h001, 1'b1, 4'd6}, // R6 right bank
        '{1'b0, 32'h0,     1'b1, 32'h400,  1'b1, 12'h001, 1'b1, 4'd4}, // R4 no clash
        '{1'b0, 32'h0,     1'b1, 32'h4000, 1'b1, 12'h010, 1'b1, 4'd4},
        '{1'b0, 32'h0,     1'b0, 32'h0,    1'b1, 12'h001, 1'b0, 4'd4}, // R4 evicted
        '{1'b0, 32'h0,     1'b0, 32'h0,    1'b1, 12'h100, 1'b1, 4'd5}, // R5
        '{1'b1, 32'h1C0,   1'b1, 32'h200,  1'b0, 12'h000, 1'b0, 4'd9},
        '{1'b0, 32'h0,     1'b0, 32'h0,    1'b1, 12'h007, 1'b1, 4'd9}, // R9
        '{1'b0, 32'h0,     1'b0, 32'h0,    1'b1, 12'h008, 1'b1, 4'd9},
        '{1'b0, 32'h0,     1'b0, 32'h0,    1'b0, 12'h007, 1'b0, 4'd7}, // R7 no req
        '{1'b1, 32'h8016A, 1'b0, 32'h0,    1'b1, 12'h005, 1'b0, 4'd2},
        '{1'b0, 32'h0,     1'b0, 32'h0,    1'b1, 12'h005, 1'b1, 4'd2}, // R2 masking
        '{1'b0, 32'h0,     1'b0, 32'h0,    1'b1, 12'h200, 1'b0, 4'd2}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          wl_en, wr_en, lk_en;
    logic [AW-1:0] wl_addr, wr_addr;
    logic [TW-1:0] lk_tag;
    logic          lk_hit;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    rrt_table u_dut (
        .clk     (clk),
        .rst     (rst),
        .wl_en   (wl_en),
        .wl_addr (wl_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .lk_en   (lk_en),
        .lk_tag  (lk_tag),
        .lk_hit  (lk_hit)
    );

    task automatic check(input logic exp, input int req);
        checks++;
        if (lk_hit !== exp) begin
            errors++;
            $display("FAIL R%0d: lk_hit=%b expected %b", req, lk_hit, exp);
        end
    endtask

    task automatic step(input vec_t v);
        @(negedge clk);
        wl_en = v.wl; wl_addr = v.wla;
        wr_en = v.wr; wr_addr = v.wra;
        lk_en = v.lk; lk_tag = v.tag;
        @(posedge clk);
        #1;
        check(v.exp, int'(v.req));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wl_en = 0; wr_en = 0; lk_en = 0;
        wl_addr = '0; wr_addr = '0; lk_tag = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; wl_en = 0; wr_en = 0; lk_en = 0;
        wl_addr = '0; wr_addr = '0; lk_tag = '0;
        do_reset();
        // R1: output low out of reset
        check(1'b0, 1);
        for (int i = 0; i < NV; i++) step(VEC[i]);

        // R1: reset clears entries written above
        do_reset();
        step('{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 12'h010, 1'b0, 4'd1});
        step('{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 12'h005, 1'b0, 4'd1});

        // R6: fill every left slot (line i -> slot i), then probe each tag
        for (int i = 0; i < 16; i++)
            step('{1'b1, AW'(i * 64), 1'b0, 32'h0, 1'b0, 12'h000, 1'b0, 4'd6});
        for (int i = 0; i < 16; i++)
            step('{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, TW'(i), 1'b1, 4'd6});
        step('{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 12'h010, 1'b0, 4'd6});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule